// File: doc/BRIEF.md
# I2C Register-File Target Engine

This block is a serial-bus target that answers on a fixed 7-bit device address and gives byte-wide access to a 64-entry register space. Entries 0 to 7 belong to a neighbouring timekeeping core. Entries 8 to 63 are a 56-byte general-purpose RAM held inside the engine. A 6-bit pointer selects the entry. A write transaction loads the pointer and then stores bytes at it. A read transaction streams bytes from the pointer for as long as the bus master acknowledges. The pointer wraps from 63 back to 0, so a burst can run from the RAM into the timekeeping entries.

The bus lines are brought into the system clock domain through two-flop synchronisers, and all decisions are made on the synchronised values. At every START the engine pulses `snap_req_o` and captures the timekeeping core's 8 bytes, so a burst reads one coherent time value. A write to entries 0 to 7 is not stored locally. It is passed to the core as a one-cycle strobe with the entry index and the data byte. The engine never drives SDA high. It only asserts `sda_pull_o`, which the pad turns into an open-drain pull-down.

The controller has eleven states. A START from any state goes to START_WAIT, and a STOP from any state goes to IDLE. Every other step happens on a falling SCL:
- START_WAIT goes to ADDR.
- ADDR collects eight bits. It then goes to ADDR_WACK on a write address, to ADDR_RACK on a read address, and to IDLE on any other byte.
- ADDR_WACK goes to PTR. PTR collects eight bits and goes to PTR_ACK.
- PTR_ACK and WACK both go to WDATA. WDATA collects eight bits, stores the byte and goes to WACK.
- ADDR_RACK goes to RDATA. RDATA shifts out eight bits and goes to RACK.
- RACK goes back to RDATA on a master ACK and to IDLE on a master NACK.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset the engine is idle with SDA released and the pointer at 0, so the first read transaction returns entry 0.
- R2: Address byte 0xD0 (device address 0x68 with the direction bit 0) is acknowledged as a write, and 0xD1 (direction bit 1) as a read. Any other address byte gets no ACK (SDA reads 1 in the ACK slot), and the bytes that follow it up to the next START are ignored and not acknowledged.
- R3: In a write transaction the first data byte sets the pointer to its low 6 bits, and bits 7:6 are ignored. Each further byte is stored at the pointer, and the pointer then increments modulo 64. All these bytes are acknowledged.
- R4: Pointer values 8 to 63 address a 56-byte RAM that reads back exactly what was written.
- R5: A byte written to entries 0 to 7 causes a single one-cycle `wr_stb_o` pulse, with `wr_idx_o` set to the entry and `wr_data_o` to the byte. It changes no RAM entry.
- R6: A read returns bytes MSB first, starting at the current pointer. Each master ACK increments the pointer modulo 64 and sends the next entry, so entry 63 is followed by entry 0.
- R7: A master NACK after a read byte ends the burst. The pointer is not incremented, and SDA stays released until the next START.
- R8: Each START pulses `snap_req_o` once and captures `snap_data_i` (byte i in bits 8i+7:8i). Reads of entries 0 to 7 return the captured bytes, even if `snap_data_i` changes later in the same transaction.
- R9: A STOP returns the engine to idle from any state, and bytes clocked after it without a START are not acknowledged and have no effect.
- R10: The engine pulls SDA low only in ACK slots of the address, pointer and write data bytes, and for 0 bits of read data. It starts pulling only while SCL is low.
- R11: A repeated START without an intervening STOP restarts address collection, so a write of the pointer followed by a repeated START and a read address reads from that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| snap_req_o | output | 1 | One-cycle pulse at each START; snapshot taken in the same cycle |
| snap_data_i | input | 64 | Live timekeeping entries 0 to 7, byte i at bits 8i+7:8i |
| wr_stb_o | output | 1 | One-cycle strobe for a write to entries 0 to 7 |
| wr_idx_o | output | 3 | Entry index of the strobed write |
| wr_data_o | output | 8 | Data byte of the strobed write |

## Verification
The bound checker watches on every cycle that a STOP always lands the controller in IDLE and that a START request is followed by START_WAIT. It also checks that SDA is never pulled in IDLE, START_WAIT or the master-acknowledge slot, that a new pull begins only while SCL is low, and that each write strobe is a single cycle following a falling SCL. Only the bench's transactions can show the data path: pointer loading with bits 7:6 ignored, the wrap from 63 to 0 into the snapshot, the snapshot holding old values after `snap_data_i` changes, the pointer not advancing on a NACK, and bytes after a bad address or a STOP leaving the RAM untouched.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_WAIT,
        ST_ADDR,
        ST_ADDR_WACK,
        ST_ADDR_RACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } rf_state_e;

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] syn;
    logic [NLINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end
        assign syn[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= syn;
        end
    end

    assign scl_s     = syn[0];
    assign sda_s     = syn[1];
    assign scl_fall  = prev[0] & ~syn[0];
    assign start_det = prev[0] & syn[0] & prev[1] & ~syn[1];
    assign stop_det  = prev[0] & syn[0] & ~prev[1] & syn[1];

endmodule

// File: rtl/i2c_rf_snap.sv
module i2c_rf_snap #(
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [NREG*8-1:0] din,
    input  logic [IDX_W-1:0]  idx,
    output logic [7:0]        dout
);
    logic [7:0] bank [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[i] <= '0;
            end else if (cap) begin
                bank[i] <= din[8*i +: 8];
            end
        end
    end

    assign dout = bank[idx];

endmodule

// File: rtl/i2c_rf_ram.sv
module i2c_rf_ram #(
    parameter int DEPTH = 56,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         PTR_W    = 6,
    parameter int         NREG     = 8,
    parameter int         SYNC_STG = 2,
    localparam int        NENT     = 1 << PTR_W,
    localparam int        RAM_DEPTH = NENT - NREG,
    localparam int        RAM_AW   = $clog2(RAM_DEPTH),
    localparam int        IDX_W    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              snap_req_o,
    input  logic [NREG*8-1:0] snap_data_i,
    output logic              wr_stb_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [7:0]        wr_data_o
);
    logic scl_s, sda_s, scl_fall, start_det, stop_det;

    rf_state_e        st_q, st_d;
    logic [7:0]       sh_q, sh_d, sh_nx;
    logic [2:0]       cnt_q, cnt_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [7:0]       tx_q, tx_d;
    logic             last_bit;
    logic             ram_we, stb_d;
    logic [PTR_W-1:0] rd_addr, ram_off_rd, ram_off_wr;
    logic [7:0]       snap_dout, ram_dout, rd_data;

    i2c_rf_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // read source: next entry while answering a master ACK, else the pointer
    assign rd_addr    = (st_q == ST_RACK) ? ptr_q + PTR_W'(1) : ptr_q;
    assign ram_off_rd = rd_addr - PTR_W'(NREG);
    assign ram_off_wr = ptr_q - PTR_W'(NREG);

    i2c_rf_snap #(.NREG(NREG)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (start_det),
        .din   (snap_data_i),
        .idx   (rd_addr[IDX_W-1:0]),
        .dout  (snap_dout)
    );

    i2c_rf_ram #(.DEPTH(RAM_DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_off_wr[RAM_AW-1:0]),
        .wdata (sh_nx),
        .raddr (ram_off_rd[RAM_AW-1:0]),
        .rdata (ram_dout)
    );

    assign rd_data    = (rd_addr < PTR_W'(NREG)) ? snap_dout : ram_dout;
    assign snap_req_o = start_det;
    assign sh_nx      = {sh_q[6:0], sda_s};
    assign last_bit   = (cnt_q == 3'd7);

    // next-state and datapath update
    always_comb begin
        st_d   = st_q;
        sh_d   = sh_q;
        cnt_d  = cnt_q;
        ptr_d  = ptr_q;
        tx_d   = tx_q;
        ram_we = 1'b0;
        stb_d  = 1'b0;
        if (stop_det) begin
            st_d = ST_IDLE;
        end else if (start_det) begin
            st_d  = ST_START_WAIT;
            cnt_d = '0;
        end else if (scl_fall) begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_START_WAIT: begin
                    st_d  = ST_ADDR;
                    cnt_d = '0;
                end
                ST_ADDR: begin
                    sh_d  = sh_nx;
                    cnt_d = cnt_q + 3'd1;
                    if (last_bit) begin
                        if (sh_nx == {DEV_ADDR, 1'b0})      st_d = ST_ADDR_WACK;
                        else if (sh_nx == {DEV_ADDR, 1'b1}) st_d = ST_ADDR_RACK;
                        else                                st_d = ST_IDLE;
                    end
                end
                ST_ADDR_WACK: begin
                    st_d  = ST_PTR;
                    cnt_d = '0;
                end
                ST_ADDR_RACK: begin
                    st_d  = ST_RDATA;
                    tx_d  = rd_data;
                    cnt_d = '0;
                end
                ST_PTR: begin
                    sh_d  = sh_nx;
                    cnt_d = cnt_q + 3'd1;
                    if (last_bit) begin
                        ptr_d = sh_nx[PTR_W-1:0];
                        st_d  = ST_PTR_ACK;
                    end
                end
                ST_PTR_ACK, ST_WACK: begin
                    st_d  = ST_WDATA;
                    cnt_d = '0;
                end
                ST_WDATA: begin
                    sh_d  = sh_nx;
                    cnt_d = cnt_q + 3'd1;
                    if (last_bit) begin
                        if (ptr_q < PTR_W'(NREG)) stb_d  = 1'b1;
                        else                      ram_we = 1'b1;
                        ptr_d = ptr_q + PTR_W'(1);
                        st_d  = ST_WACK;
                    end
                end
                ST_RDATA: begin
                    cnt_d = cnt_q + 3'd1;
                    if (last_bit) st_d = ST_RACK;
                end
                ST_RACK: begin
                    if (!sda_s) begin
                        st_d  = ST_RDATA;
                        ptr_d = ptr_q + PTR_W'(1);
                        tx_d  = rd_data;
                        cnt_d = '0;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            sh_q      <= '0;
            cnt_q     <= '0;
            ptr_q     <= '0;
            tx_q      <= '0;
            wr_stb_o  <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            st_q     <= st_d;
            sh_q     <= sh_d;
            cnt_q    <= cnt_d;
            ptr_q    <= ptr_d;
            tx_q     <= tx_d;
            wr_stb_o <= stb_d;
            if (stb_d) begin
                wr_idx_o  <= ptr_q[IDX_W-1:0];
                wr_data_o <= sh_nx;
            end
        end
    end

    // line output per state
    always_comb begin
        unique case (st_q)
            ST_ADDR_WACK, ST_ADDR_RACK, ST_PTR_ACK, ST_WACK: sda_pull_o = 1'b1;
            ST_RDATA: sda_pull_o = ~tx_q[3'd7 - cnt_q];
            default:  sda_pull_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker
    import i2c_rf_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input rf_state_e st,
    input logic      sda_pull,
    input logic      snap_req,
    input logic      wr_stb,
    input logic      stop_det,
    input logic      scl_fall,
    input logic      scl_s
);

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE));

    assert_start_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (st == ST_START_WAIT));

    assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RACK) |-> !sda_pull);

    assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) || (st == ST_START_WAIT)) |-> !sda_pull);

    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_stb_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stb) |-> $past(scl_fall));

endmodule

bind i2c_regfile_target i2c_rf_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st_q),
    .sda_pull (sda_pull_o),
    .snap_req (snap_req_o),
    .wr_stb   (wr_stb_o),
    .stop_det (stop_det),
    .scl_fall (scl_fall),
    .scl_s    (scl_s)
);

// File: tb/sim_i2c_regfile_target.sv
`timescale 1ns/1ps
module sim_i2c_regfile_target;

    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        msda = 1'b1;
    logic        sda_line;
    logic        sda_pull_o, snap_req_o, wr_stb_o;
    logic [63:0] snap_data_i;
    logic [2:0]  wr_idx_o;
    logic [7:0]  wr_data_o;

    int checks = 0;
    int errors = 0;
    int snap_seen = 0;
    int snap_exp = 0;
    logic [10:0] exp_q [$];

    always #2.5 clk = ~clk;

    assign sda_line = msda & ~sda_pull_o;

    i2c_regfile_target u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull_o),
        .snap_req_o  (snap_req_o),
        .snap_data_i (snap_data_i),
        .wr_stb_o    (wr_stb_o),
        .wr_idx_o    (wr_idx_o),
        .wr_data_o   (wr_data_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: strobes popped from the scoreboard, snapshot pulses counted
    always @(negedge clk) begin
        if (rst_n && snap_req_o) snap_seen++;
        if (rst_n && wr_stb_o) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected strobe", {21'd0, wr_idx_o, wr_data_o}, 32'hFFFF);
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                check("R5 strobe idx/data", {21'd0, wr_idx_o, wr_data_o}, {21'd0, e});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_out(input logic b);
        tick(Q); msda = b;
        tick(Q); scl = 1'b1;
        tick(2*Q); scl = 1'b0;
    endtask

    task automatic bit_in(output logic r);
        tick(Q); msda = 1'b1;
        tick(Q); scl = 1'b1;
        tick(Q); r = sda_line;
        tick(Q); scl = 1'b0;
    endtask

    task automatic do_start();
        tick(Q); msda = 1'b1;
        tick(Q); scl = 1'b1;
        tick(Q); msda = 1'b0;
        snap_exp++;
        tick(Q); scl = 1'b0;
    endtask

    task automatic do_stop();
        tick(Q); msda = 1'b0;
        tick(Q); scl = 1'b1;
        tick(Q); msda = 1'b1;
        tick(Q);
    endtask

    task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        check(tag, {31'd0, a}, {31'd0, exp_ack});
    endtask

    task automatic recv(input logic [7:0] exp, input logic nack, input string tag);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        bit_out(nack);
        check(tag, {24'd0, v}, {24'd0, exp});
    endtask

    task automatic set_snap(input logic [7:0] base);
        for (int i = 0; i < 8; i++) snap_data_i[8*i +: 8] = base + 8'(i);
    endtask

    task automatic push_stb(input logic [2:0] idx, input logic [7:0] d);
        exp_q.push_back({idx, d});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic a;
        set_snap(8'hA0);
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        check("R1 sda released", {31'd0, sda_pull_o}, 0);
        check("R1 no strobe", {31'd0, wr_stb_o}, 0);

        // R1/R6 read from pointer 0 after reset
        do_start();
        send(8'hD1, 1'b0, "R2 read address ack");
        recv(8'hA0, 1'b0, "R1 first read entry 0");
        recv(8'hA1, 1'b1, "R6 ack increments");
        do_stop();

        // R3 pointer load with bits 7:6 ignored, burst write to RAM
        do_start();
        send(8'hD0, 1'b0, "R2 write address ack");
        send(8'hC8, 1'b0, "R3 pointer ack");
        send(8'h5A, 1'b0, "R3 data ack");
        send(8'h3C, 1'b0, "R3 data ack");
        send(8'h81, 1'b0, "R3 data ack");
        do_stop();
        // R4/R11 read back via repeated START
        do_start();
        send(8'hD0, 1'b0, "R11 write address");
        send(8'h08, 1'b0, "R11 pointer");
        do_start();
        send(8'hD1, 1'b0, "R11 read after restart");
        recv(8'h5A, 1'b0, "R4 ram 8");
        recv(8'h3C, 1'b0, "R4 ram 9");
        recv(8'h81, 1'b1, "R4 ram 10");
        do_stop();

        // R5 writes to clock entries become strobes, crossing into RAM
        do_start();
        send(8'hD0, 1'b0, "R5 address");
        send(8'h06, 1'b0, "R5 pointer");
        push_stb(3'd6, 8'h11);
        send(8'h11, 1'b0, "R5 entry 6");
        push_stb(3'd7, 8'h22);
        send(8'h22, 1'b0, "R5 entry 7");
        send(8'h33, 1'b0, "R5 entry 8");
        do_stop();
        do_start();
        send(8'hD0, 1'b0, "R5 address");
        send(8'h08, 1'b0, "R5 pointer");
        do_start();
        send(8'hD1, 1'b0, "R5 read address");
        recv(8'h33, 1'b1, "R5 ram 8 after crossing");
        do_stop();

        // R6 wrap 63 -> 0
        do_start();
        send(8'hD0, 1'b0, "R6 address");
        send(8'h3F, 1'b0, "R6 pointer 63");
        send(8'h77, 1'b0, "R6 ram 63");
        push_stb(3'd0, 8'h99);
        send(8'h99, 1'b0, "R6 wrapped write entry 0");
        do_stop();
        do_start();
        send(8'hD0, 1'b0, "R6 address");
        send(8'h3F, 1'b0, "R6 pointer");
        do_start();
        send(8'hD1, 1'b0, "R6 read address");
        recv(8'h77, 1'b0, "R6 entry 63");
        recv(8'hA0, 1'b1, "R6 wrap to entry 0");
        do_stop();

        // R8 snapshot held; R7 NACK keeps pointer and releases line
        do_start();
        send(8'hD0, 1'b0, "R8 address");
        send(8'h02, 1'b0, "R8 pointer 2");
        do_stop();
        do_start();
        send(8'hD1, 1'b0, "R8 read address");
        set_snap(8'hC0);
        recv(8'hA2, 1'b1, "R8 snapshot from START");
        bit_in(a);
        check("R7 released after nack", {31'd0, a}, 1);
        do_stop();
        do_start();
        send(8'hD1, 1'b0, "R7 read address");
        recv(8'hC2, 1'b1, "R7 pointer kept, R8 new snapshot");
        do_stop();

        // R2 foreign address ignored with following bytes
        do_start();
        send(8'hA0, 1'b1, "R2 foreign address nack");
        send(8'h09, 1'b1, "R2 ignored byte");
        send(8'h55, 1'b1, "R2 ignored byte");
        do_stop();
        do_start();
        send(8'hD0, 1'b0, "R2 address");
        send(8'h09, 1'b0, "R2 pointer");
        do_start();
        send(8'hD1, 1'b0, "R2 read address");
        recv(8'h3C, 1'b1, "R2 ram 9 untouched");
        do_stop();

        // R9 STOP forces idle; R10 line released after STOP
        do_start();
        send(8'hD0, 1'b0, "R9 address");
        send(8'h0A, 1'b0, "R9 pointer");
        do_stop();
        check("R10 released after stop", {31'd0, sda_pull_o}, 0);
        tick(Q); scl = 1'b0;
        send(8'h0B, 1'b1, "R9 byte after stop");
        send(8'h66, 1'b1, "R9 byte after stop");
        do_start();
        send(8'hD0, 1'b0, "R9 address");
        send(8'h0A, 1'b0, "R9 pointer");
        do_start();
        send(8'hD1, 1'b0, "R9 read address");
        recv(8'h81, 1'b1, "R9 ram 10 untouched");
        do_stop();
        check("R10 released at end", {31'd0, sda_pull_o}, 0);

        tick(10);
        check("R8 snapshot pulses", snap_seen, snap_exp);
        check("R5 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule